// File: doc/BRIEF.md
# Leaf Page-Entry Access Checker

This block decides whether a leaf entry returned by a page-table walk authorises the access that caused the walk. Each request presents the 64-bit leaf entry together with three qualifiers: whether the access runs in privileged mode, whether it is an instruction fetch, and whether it is a store. One clock later the block raises a result strobe carrying exactly one of three verdicts: the access is allowed and the translation may be installed, the access is refused for lack of authority, or authority is present but the reference/change state of the entry does not permit the access yet.

The authority check combines a privileged-only page bit, separate read, read/write and execute grants, and a rule that no code is fetched from a cache-inhibited page. The reference/change check needs the reference bit for every access and the change bit for stores. A fetch is never treated as a store. When authority fails, only the authority error is reported, whatever the reference/change state.

The verdict register is driven by a two-state machine. `ST_IDLE` holds no result; the transition *accept* (request strobe high) moves it to `ST_REPORT`, which presents the verdict for one cycle. From `ST_REPORT`, *chain* (another request strobe) stays in `ST_REPORT` with the new verdict, and *drain* (no request) returns to `ST_IDLE`. Reset forces `ST_IDLE`.

Top module: `leaf_pte_checker`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high for the following cycle only; back-to-back requests produce back-to-back results, each matching its own request.
- R2: With `rsp_valid` high exactly one of `rsp_ok`, `rsp_perm_err`, `rsp_rc_err` is high; with `rsp_valid` low all three are low, and all outputs are low during and right after reset.
- R3: When the access is not privileged and entry bit 3 (privileged-only page) is set, authority is denied whatever the grant bits are; a privileged access ignores bit 3.
- R4: A data load (fetch low, store low) has authority when entry bit 1 (read/write) or entry bit 2 (read) is set.
- R5: A data store (fetch low, store high) has authority only when entry bit 1 is set; bit 2 alone is not enough.
- R6: An instruction fetch has authority only when entry bit 0 (execute) is set and entry bit 5 is clear; bits 1 and 2 grant nothing to a fetch.
- R7: A fetch with `req_store` also high is judged as a fetch that is not a store: it needs neither bit 1 nor the change bit.
- R8: Given authority, the result is ok only when entry bit 8 (reference) is set and, for a store, entry bit 7 (change) is also set; otherwise it is a reference/change error.
- R9: When authority is denied the result is `rsp_perm_err` alone, even if the reference/change check also fails.
- R10: Entry bits 5:4 are the memory attribute (00 normal, 10 non-idempotent, 11 tolerant I/O); any attribute with bit 5 set refuses a fetch, while data accesses are unaffected by the attribute; entry bits other than 0, 1, 2, 3, 5, 7 and 8 have no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_pte | input | 64 | Leaf page-table entry under test |
| req_priv | input | 1 | Access runs in privileged mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_store | input | 1 | Access is a store (ignored for fetches) |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_ok | output | 1 | Access allowed |
| rsp_perm_err | output | 1 | Authority denied |
| rsp_rc_err | output | 1 | Authority present, reference/change state insufficient |

## Verification
Loads, stores and fetches are each applied against entries granting only read, only read/write, only execute and nothing, which separates the three grant bits and shows that a store is not satisfied by the read grant. Unprivileged and privileged accesses to a privileged-only page show the gate, and a fetch with the store flag also set shows that the change bit and write grant are not demanded of it. Entries missing the reference or change bit, alone and combined with a denied grant, tell the reference/change error apart from the precedence of the authority error, and all four attribute codes plus junk in unused upper bits check which bits are ignored; a back-to-back pair with opposite verdicts shows that results stay tied to their own requests.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    // Verdict machine states
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } lpc_state_e;

    // One-hot verdict carried with each result strobe
    typedef struct packed {
        logic ok;
        logic perm_err;
        logic rc_err;
    } lpc_verdict_t;

    // Entry bit positions (LSB = 0)
    localparam int unsigned PB_EXEC     = 0;
    localparam int unsigned PB_RDWR     = 1;
    localparam int unsigned PB_RDONLY   = 2;
    localparam int unsigned PB_PRIVONLY = 3;
    localparam int unsigned PB_ATTR_LO  = 4;
    localparam int unsigned PB_ATTR_HI  = 5;
    localparam int unsigned PB_CHANGE   = 7;
    localparam int unsigned PB_REF      = 8;

endpackage

// File: rtl/lpc_perm_eval.sv
module lpc_perm_eval (
    input  logic g_exec,
    input  logic g_rdwr,
    input  logic g_rdonly,
    input  logic g_privonly,
    input  logic attr_inhibit,
    input  logic acc_priv,
    input  logic acc_fetch,
    input  logic acc_store_eff,
    output logic perm_ok
);

    logic gate_open;
    logic data_grant;
    logic fetch_grant;

    always_comb begin
        // privileged-only pages refuse unprivileged accesses outright
        gate_open   = acc_priv | ~g_privonly;
        data_grant  = g_rdwr | (g_rdonly & ~acc_store_eff);
        fetch_grant = g_exec & ~attr_inhibit;
        perm_ok     = gate_open & (acc_fetch ? fetch_grant : data_grant);
    end

endmodule

// File: rtl/lpc_rc_eval.sv
module lpc_rc_eval (
    input  logic ref_bit,
    input  logic chg_bit,
    input  logic acc_store_eff,
    output logic rc_ok
);

    always_comb begin
        rc_ok = ref_bit & (chg_bit | ~acc_store_eff);
    end

endmodule

// File: rtl/lpc_verdict_fsm.sv
module lpc_verdict_fsm
    import lpc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic         perm_ok,
    input  logic         rc_ok,
    output logic         out_valid,
    output lpc_verdict_t out_verdict
);

    lpc_state_e   state_q;
    lpc_state_e   state_d;
    lpc_verdict_t verdict_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_REPORT;   // accept
            ST_REPORT: if (!req_valid) state_d = ST_IDLE;    // drain (else chain)
            default:   state_d = ST_IDLE;
        endcase
    end

    // verdict priority: authority failure masks reference/change failure
    always_comb begin
        verdict_d.ok       = perm_ok & rc_ok;
        verdict_d.perm_err = ~perm_ok;
        verdict_d.rc_err   = perm_ok & ~rc_ok;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_verdict <= '0;
        end else if (req_valid) begin
            out_verdict <= verdict_d;
        end else begin
            out_verdict <= '0;
        end
    end

    assign out_valid = (state_q == ST_REPORT);

endmodule

// File: rtl/leaf_pte_checker.sv
module leaf_pte_checker
    import lpc_pkg::*;
#(
    parameter int unsigned PTE_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [PTE_W-1:0] req_pte,
    input  logic             req_priv,
    input  logic             req_fetch,
    input  logic             req_store,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic             rsp_perm_err,
    output logic             rsp_rc_err
);

    localparam int unsigned HI_FIRST = PB_REF + 1;

    logic         store_eff;
    logic         perm_ok;
    logic         rc_ok;
    lpc_verdict_t verdict;
    logic         unused_pte_bits;

    // a fetch never counts as a store
    assign store_eff = req_store & ~req_fetch;

    assign unused_pte_bits = ^{req_pte[PTE_W-1:HI_FIRST], req_pte[6], req_pte[PB_ATTR_LO]};

    lpc_perm_eval u_perm (
        .g_exec        (req_pte[PB_EXEC]),
        .g_rdwr        (req_pte[PB_RDWR]),
        .g_rdonly      (req_pte[PB_RDONLY]),
        .g_privonly    (req_pte[PB_PRIVONLY]),
        .attr_inhibit  (req_pte[PB_ATTR_HI]),
        .acc_priv      (req_priv),
        .acc_fetch     (req_fetch),
        .acc_store_eff (store_eff),
        .perm_ok       (perm_ok)
    );

    lpc_rc_eval u_rc (
        .ref_bit       (req_pte[PB_REF]),
        .chg_bit       (req_pte[PB_CHANGE]),
        .acc_store_eff (store_eff),
        .rc_ok         (rc_ok)
    );

    lpc_verdict_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .perm_ok     (perm_ok),
        .rc_ok       (rc_ok),
        .out_valid   (rsp_valid),
        .out_verdict (verdict)
    );

    assign rsp_ok       = verdict.ok;
    assign rsp_perm_err = verdict.perm_err;
    assign rsp_rc_err   = verdict.rc_err;

endmodule

// File: rtl/leaf_pte_checker_sva.sv
module leaf_pte_checker_sva #(
    parameter int unsigned PTE_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [PTE_W-1:0] req_pte,
    input logic             req_priv,
    input logic             req_fetch,
    input logic             req_store,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic             rsp_perm_err,
    input logic             rsp_rc_err
);

    // R1: result strobe follows request by one cycle
    a_r1_strobe_delay: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2: one verdict per strobe, none without
    a_r2_one_verdict: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_ok, rsp_perm_err, rsp_rc_err}) == 1));
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> ({rsp_ok, rsp_perm_err, rsp_rc_err} == 3'b000));

    // R3: privileged-only page refuses unprivileged access
    a_r3_priv_gate: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && req_pte[3]) |=> rsp_perm_err);

    // R6 / R10: no fetch from a page with attribute bit 5 set
    a_r10_fetch_inhibit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fetch && req_pte[5]) |=> rsp_perm_err);

    // R8: missing reference bit never yields ok
    a_r8_ref_needed: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_pte[8]) |=> !rsp_ok);

    // R7: fetch with store flag is not held to the change bit
    a_r7_fetch_not_store: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fetch && req_store && req_pte[0] && !req_pte[5]
         && req_pte[8] && (req_priv || !req_pte[3])) |=> rsp_ok);

endmodule

bind leaf_pte_checker leaf_pte_checker_sva #(.PTE_W(PTE_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_pte      (req_pte),
    .req_priv     (req_priv),
    .req_fetch    (req_fetch),
    .req_store    (req_store),
    .rsp_valid    (rsp_valid),
    .rsp_ok       (rsp_ok),
    .rsp_perm_err (rsp_perm_err),
    .rsp_rc_err   (rsp_rc_err)
);

// File: tb/leaf_pte_checker_tb.sv
module leaf_pte_checker_tb;

    localparam logic [63:0] X_EXEC = 64'h1;
    localparam logic [63:0] X_RW   = 64'h2;
    localparam logic [63:0] X_RD   = 64'h4;
    localparam logic [63:0] X_PRIV = 64'h8;
    localparam logic [63:0] X_A4   = 64'h10;
    localparam logic [63:0] X_A5   = 64'h20;
    localparam logic [63:0] X_CHG  = 64'h80;
    localparam logic [63:0] X_REF  = 64'h100;

    localparam int V_OK = 0, V_PERM = 1, V_RC = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_pte = '0;
    logic        req_priv = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_store = 1'b0;
    logic        rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    leaf_pte_checker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_pte(req_pte),
        .req_priv(req_priv), .req_fetch(req_fetch), .req_store(req_store),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_perm_err(rsp_perm_err), .rsp_rc_err(rsp_rc_err)
    );

    task automatic compare(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: {valid,ok,perm,rc} got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] expect_of(input int v);
        case (v)
            V_OK:    return 4'b1100;
            V_PERM:  return 4'b1010;
            default: return 4'b1001;
        endcase
    endfunction

    // drive one request, sample its result one cycle later
    task automatic probe(input string tag, input logic [63:0] pte,
                         input logic priv, input logic fetch, input logic store,
                         input int v);
        @(negedge clk);
        req_valid = 1'b1; req_pte = pte;
        req_priv = priv; req_fetch = fetch; req_store = store;
        @(negedge clk);
        req_valid = 1'b0; req_pte = '0;
        req_priv = 1'b0; req_fetch = 1'b0; req_store = 1'b0;
        compare(tag, {rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err}, expect_of(v));
    endtask

    task automatic t_reset;
        @(negedge clk);
        compare("R2 reset held", {rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err}, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        compare("R2 after reset", {rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err}, 4'b0000);
    endtask

    task automatic t_load;
        probe("R4 load read-only",  X_REF | X_RD, 0, 0, 0, V_OK);
        probe("R4 load read/write", X_REF | X_RW, 0, 0, 0, V_OK);
        probe("R4 load no grant",   X_REF | X_EXEC, 0, 0, 0, V_PERM);
    endtask

    task automatic t_store;
        probe("R5 store rw",        X_REF | X_CHG | X_RW, 0, 0, 1, V_OK);
        probe("R5 store read-only", X_REF | X_CHG | X_RD, 0, 0, 1, V_PERM);
    endtask

    task automatic t_fetch;
        probe("R6 fetch exec",      X_REF | X_EXEC, 0, 1, 0, V_OK);
        probe("R6 fetch rw+rd",     X_REF | X_RW | X_RD, 0, 1, 0, V_PERM);
        probe("R7 fetch with store",X_REF | X_EXEC, 0, 1, 1, V_OK);
    endtask

    task automatic t_priv;
        probe("R3 unpriv on priv page", X_REF | X_RD | X_PRIV, 0, 0, 0, V_PERM);
        probe("R3 priv on priv page",   X_REF | X_RD | X_PRIV, 1, 0, 0, V_OK);
        probe("R3 unpriv plain page",   X_REF | X_RD, 0, 0, 0, V_OK);
    endtask

    task automatic t_rc;
        probe("R8 load no ref",     X_RD, 0, 0, 0, V_RC);
        probe("R8 store no change", X_REF | X_RW, 0, 0, 1, V_RC);
        probe("R8 store no ref",    X_CHG | X_RW, 1, 0, 1, V_RC);
    endtask

    task automatic t_precedence;
        probe("R9 both fail store", 64'h0, 0, 0, 1, V_PERM);
        probe("R9 priv gate no ref", X_RD | X_PRIV, 0, 0, 0, V_PERM);
    endtask

    task automatic t_attr;
        probe("R10 fetch attr 00", X_REF | X_EXEC, 1, 1, 0, V_OK);
        probe("R10 fetch attr 01", X_REF | X_EXEC | X_A4, 1, 1, 0, V_OK);
        probe("R10 fetch attr 10", X_REF | X_EXEC | X_A5, 1, 1, 0, V_PERM);
        probe("R10 fetch attr 11", X_REF | X_EXEC | X_A5 | X_A4, 1, 1, 0, V_PERM);
        probe("R10 load attr 11",  X_REF | X_RD | X_A5 | X_A4, 0, 0, 0, V_OK);
        probe("R10 upper junk",    64'hFFFF_FFFF_FFFF_FE40 | X_REF | X_RD, 0, 0, 0, V_OK);
    endtask

    task automatic t_chain;
        @(negedge clk);
        req_valid = 1'b1; req_pte = X_REF | X_RD; req_fetch = 0; req_store = 0; req_priv = 0;
        @(negedge clk);
        compare("R1 chain first", {rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err}, 4'b1100);
        req_pte = X_RD;
        @(negedge clk);
        compare("R1 chain second", {rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err}, 4'b1001);
        req_valid = 1'b0; req_pte = '0;
        @(negedge clk);
        compare("R1 drain", {rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err}, 4'b0000);
        @(negedge clk);
        compare("R2 idle quiet", {rsp_valid, rsp_ok, rsp_perm_err, rsp_rc_err}, 4'b0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_store();
        t_fetch();
        t_priv();
        t_rc();
        t_precedence();
        t_attr();
        t_chain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule